// File: doc/BRIEF.md
# SPI Flash Status Register Unit

This block holds the status register logic of a serial NOR flash device, as seen from the SPI slave side. It receives opcodes on the serial input and serves a continuous status read. It keeps a persistent lockdown-enable bit, and that bit decides whether the sector-lockdown command and the lockdown-freeze command are accepted. The memory-array controller reports the busy flag, the program-suspend flag and the erase-suspend flag on sideband inputs. Accepted lockdown, freeze and soft-reset commands leave the block as one-clock strobes, for the array logic to act on.

The serial pins are sampled by the block's own clock, through a synchronizer of configurable depth. The serial protocol is SPI mode 0: SI is taken on the rising SCK edge, and SO changes on the falling edge. Raising chip select ends any command at any bit and restarts the bit count. The power-on reset clears every bit, the lockdown freeze included. The soft-reset command does not.

Top module: `spi_status_unit`

## Requirements
- R1: Opcode 0x05, shifted in MSB first over 8 rising SCK edges, starts a status read. While the opcode is shifted in, `so_oe_o` stays 0. Status byte A comes out next, MSB first: bit 0 is busy, bit 1 is program-suspend, bit 2 is erase-suspend, and the other bits are 0.
- R2: While chip select stays low, the read alternates: A, B, A, B and so on. In status byte B, bit 0 is busy, bit 4 is the lockdown-enable bit, and the other bits are 0. Once `cs_n_i` is high, `so_oe_o` returns to 0.
- R3: The flags are captured at the start of each status byte. A flag that changes in the middle of a byte leaves that byte unchanged, and the next byte shows the new value.
- R4: After power-on reset, the lockdown-enable bit is 0, all strobes are 0 and `so_oe_o` is 0.
- R5: While the enable bit is 0, opcode 0x33 (lockdown) and opcode 0x34 (freeze) produce no strobe and change no state.
- R6: Opcode 0x31 followed by one data byte copies data bit 4 into the enable bit. The value then holds across later transactions.
- R7: Opcode 0xF0 pulses `soft_rst_o` for one clock and leaves the enable bit unchanged.
- R8: A freeze that is accepted pulses `freeze_stb_o` and clears the enable bit. After that, opcode 0x31 cannot set the bit again until the next power-on reset.
- R9: Opcode 0x33 with the enable bit at 1 pulses `lock_stb_o` for one clock.
- R10: If chip select rises partway through a command, the command is dropped and the enable bit is untouched. The next command is decoded from its first bit.
- R11: An unknown opcode gives no strobe, and `so_oe_o` stays 0 for the rest of that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples the serial pins |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sck_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO; 0 means high impedance |
| busy_i | input | 1 | Program or erase in progress |
| pgm_susp_i | input | 1 | Program suspended |
| ers_susp_i | input | 1 | Erase suspended |
| lock_en_o | output | 1 | Current lockdown-enable bit |
| lock_stb_o | output | 1 | Accepted sector-lockdown command, one clock |
| freeze_stb_o | output | 1 | Accepted lockdown-freeze command, one clock |
| soft_rst_o | output | 1 | Soft-reset command, one clock |

## Verification
The assertions assume that the serial pins and the flags are synchronous to `clk`. They also assume that each SCK phase lasts longer than the synchronizer delay, so that every SCK edge is seen as exactly one rising or falling event. The bench drives all inputs on the falling edge of `clk` and holds each SCK level for six clocks. It changes the flags only in the middle of a byte, never at a byte boundary. The strobe properties hold only if a command and the next chip-select rise are at least a few clocks apart, and the bench always leaves that gap.

// File: rtl/sr_pkg.sv
package sr_pkg;
   typedef enum logic [1:0] {
      ST_OPC   = 2'd0,
      ST_READ  = 2'd1,
      ST_WDATA = 2'd2,
      ST_HOLD  = 2'd3
   } sr_state_e;
endpackage

// File: rtl/sr_in_sync.sv
module sr_in_sync #(
   parameter int          STAGES = 2,
   parameter int          W      = 3,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] st;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= RST;
            end else begin
               st[0] <= d_i;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q_o = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sr_spi_frontend.sv
module sr_spi_frontend #(
   parameter int DW = 8,
   localparam int CW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          sck_s,
   input  logic          cs_n_s,
   input  logic          si_s,
   output logic          fall_o,
   output logic          bit0_o,
   output logic          byte_done_o,
   output logic [DW-1:0] byte_o
);
   logic          sck_q;
   logic [CW-1:0] cnt;
   logic [DW-1:0] sh;
   logic          rise;

   assign rise        = sck_s & ~sck_q & ~cs_n_s;
   assign fall_o      = ~sck_s & sck_q & ~cs_n_s;
   assign bit0_o      = (cnt == '0);
   assign byte_done_o = rise && (cnt == CW'(DW-1));
   assign byte_o      = {sh[DW-2:0], si_s};

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sck_q <= 1'b0;
         cnt   <= '0;
         sh    <= '0;
      end else begin
         sck_q <= sck_s;
         if (cs_n_s) begin
            cnt <= '0;
            sh  <= '0;
         end else if (rise) begin
            sh  <= {sh[DW-2:0], si_s};
            cnt <= (cnt == CW'(DW-1)) ? '0 : cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sr_ctrl.sv
module sr_ctrl
   import sr_pkg::*;
#(
   parameter int          DW        = 8,
   parameter logic [DW-1:0] OP_RDSR  = 8'h05,
   parameter logic [DW-1:0] OP_WRB   = 8'h31,
   parameter logic [DW-1:0] OP_LOCK  = 8'h33,
   parameter logic [DW-1:0] OP_FRZ   = 8'h34,
   parameter logic [DW-1:0] OP_SRST  = 8'hF0,
   parameter int          SLE_BIT   = 4
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          cs_n_s,
   input  logic          byte_done_i,
   input  logic [DW-1:0] byte_i,
   output sr_state_e     state_o,
   output logic          lock_en_o,
   output logic          lock_stb_o,
   output logic          freeze_stb_o,
   output logic          soft_rst_o
);
   sr_state_e state;
   logic      sle;
   logic      frozen;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state        <= ST_OPC;
         sle          <= 1'b0;
         frozen       <= 1'b0;
         lock_stb_o   <= 1'b0;
         freeze_stb_o <= 1'b0;
         soft_rst_o   <= 1'b0;
      end else begin
         lock_stb_o   <= 1'b0;
         freeze_stb_o <= 1'b0;
         soft_rst_o   <= 1'b0;
         if (cs_n_s) begin
            state <= ST_OPC;
         end else if (byte_done_i) begin
            case (state)
               ST_OPC: begin
                  state <= ST_HOLD;
                  if (byte_i == OP_RDSR) begin
                     state <= ST_READ;
                  end else if (byte_i == OP_WRB) begin
                     state <= ST_WDATA;
                  end else if (byte_i == OP_LOCK) begin
                     lock_stb_o <= sle;
                  end else if (byte_i == OP_FRZ) begin
                     if (sle) begin
                        freeze_stb_o <= 1'b1;
                        frozen       <= 1'b1;
                        sle          <= 1'b0;
                     end
                  end else if (byte_i == OP_SRST) begin
                     soft_rst_o <= 1'b1;
                  end
               end
               ST_WDATA: begin
                  if (!frozen) sle <= byte_i[SLE_BIT];
                  state <= ST_HOLD;
               end
               default: ;
            endcase
         end
      end
   end

   assign state_o   = state;
   assign lock_en_o = sle;
endmodule

// File: rtl/spi_status_unit.sv
module spi_status_unit
   import sr_pkg::*;
#(
   parameter int          DW          = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [DW-1:0] OP_RDSR    = 8'h05,
   parameter logic [DW-1:0] OP_WRB     = 8'h31,
   parameter logic [DW-1:0] OP_LOCK    = 8'h33,
   parameter logic [DW-1:0] OP_FRZ     = 8'h34,
   parameter logic [DW-1:0] OP_SRST    = 8'hF0,
   parameter int          BUSY_BIT    = 0,
   parameter int          PSUS_BIT    = 1,
   parameter int          ESUS_BIT    = 2,
   parameter int          SLE_BIT     = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic sck_i,
   input  logic cs_n_i,
   input  logic si_i,
   output logic so_o,
   output logic so_oe_o,
   input  logic busy_i,
   input  logic pgm_susp_i,
   input  logic ers_susp_i,
   output logic lock_en_o,
   output logic lock_stb_o,
   output logic freeze_stb_o,
   output logic soft_rst_o
);
   generate
      if (DW < 8) begin : g_bad_dw
         $error("DW must be at least 8");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (SLE_BIT >= DW || BUSY_BIT >= DW || PSUS_BIT >= DW || ESUS_BIT >= DW) begin : g_bad_pos
         $error("status bit position outside the byte");
      end
      if (SLE_BIT == BUSY_BIT || PSUS_BIT == BUSY_BIT || ESUS_BIT == BUSY_BIT
          || ESUS_BIT == PSUS_BIT) begin : g_bad_overlap
         $error("status bit positions overlap");
      end
   endgenerate

   logic          sck_s, cs_n_s, si_s;
   logic          fall, bit0, byte_done;
   logic [DW-1:0] rx_byte;
   sr_state_e     state;
   logic [DW-1:0] stat_a, stat_b, tx;
   logic          sel_b;

   sr_in_sync #(.STAGES(SYNC_STAGES), .W(3), .RST(3'b010)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d_i   ({sck_i, cs_n_i, si_i}),
      .q_o   ({sck_s, cs_n_s, si_s})
   );

   sr_spi_frontend #(.DW(DW)) u_fe (
      .clk         (clk),
      .por_n       (por_n),
      .sck_s       (sck_s),
      .cs_n_s      (cs_n_s),
      .si_s        (si_s),
      .fall_o      (fall),
      .bit0_o      (bit0),
      .byte_done_o (byte_done),
      .byte_o      (rx_byte)
   );

   sr_ctrl #(
      .DW(DW), .OP_RDSR(OP_RDSR), .OP_WRB(OP_WRB), .OP_LOCK(OP_LOCK),
      .OP_FRZ(OP_FRZ), .OP_SRST(OP_SRST), .SLE_BIT(SLE_BIT)
   ) u_ctrl (
      .clk          (clk),
      .por_n        (por_n),
      .cs_n_s       (cs_n_s),
      .byte_done_i  (byte_done),
      .byte_i       (rx_byte),
      .state_o      (state),
      .lock_en_o    (lock_en_o),
      .lock_stb_o   (lock_stb_o),
      .freeze_stb_o (freeze_stb_o),
      .soft_rst_o   (soft_rst_o)
   );

   always_comb begin
      stat_a           = '0;
      stat_a[BUSY_BIT] = busy_i;
      stat_a[PSUS_BIT] = pgm_susp_i;
      stat_a[ESUS_BIT] = ers_susp_i;
      stat_b           = '0;
      stat_b[BUSY_BIT] = busy_i;
      stat_b[SLE_BIT]  = lock_en_o;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         tx    <= '0;
         sel_b <= 1'b0;
      end else if (state != ST_READ) begin
         sel_b <= 1'b0;
      end else if (fall) begin
         if (bit0) begin
            tx    <= sel_b ? stat_b : stat_a;
            sel_b <= ~sel_b;
         end else begin
            tx <= {tx[DW-2:0], 1'b0};
         end
      end
   end

   assign so_o    = tx[DW-1];
   assign so_oe_o = (state == ST_READ);
endmodule

// File: rtl/spi_status_unit_chk.sv
module spi_status_unit_chk (
   input logic clk,
   input logic por_n,
   input logic cs_n_s,
   input logic so_oe_o,
   input logic lock_en_o,
   input logic lock_stb_o,
   input logic freeze_stb_o,
   input logic soft_rst_o
);
   AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!por_n)
      cs_n_s |=> !so_oe_o); // R2
   AST_FREEZE_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
      freeze_stb_o |-> $past(lock_en_o)); // R5
   AST_FREEZE_CLEARS_EN: assert property (@(posedge clk) disable iff (!por_n)
      freeze_stb_o |-> !lock_en_o); // R8
   AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
      lock_stb_o |-> lock_en_o); // R9
   AST_SOFT_RST_KEEPS_EN: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst_o |-> $stable(lock_en_o)); // R7
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0({lock_stb_o, freeze_stb_o, soft_rst_o})); // R11
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
      (lock_stb_o || freeze_stb_o || soft_rst_o) |=> !(lock_stb_o || freeze_stb_o || soft_rst_o)); // R9
endmodule

bind spi_status_unit spi_status_unit_chk u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .cs_n_s       (cs_n_s),
   .so_oe_o      (so_oe_o),
   .lock_en_o    (lock_en_o),
   .lock_stb_o   (lock_stb_o),
   .freeze_stb_o (freeze_stb_o),
   .soft_rst_o   (soft_rst_o)
);

// File: tb/spi_status_unit_test.sv
module spi_status_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
   logic busy = 1'b0, pgm = 1'b0, ers = 1'b0;
   logic so, so_oe, lock_en, lock_stb, freeze_stb, soft_rst;

   int total = 0, bad = 0;
   int n_lock = 0, n_frz = 0, n_rst = 0;
   bit m_sle = 0, m_frozen = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_status_unit uut (
      .clk(clk), .por_n(por_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
      .so_o(so), .so_oe_o(so_oe), .busy_i(busy), .pgm_susp_i(pgm),
      .ers_susp_i(ers), .lock_en_o(lock_en), .lock_stb_o(lock_stb),
      .freeze_stb_o(freeze_stb), .soft_rst_o(soft_rst)
   );

   always @(posedge clk) begin
      if (lock_stb)   n_lock++;
      if (freeze_stb) n_frz++;
      if (soft_rst)   n_rst++;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] byte_a();
      return {5'b0, ers, pgm, busy};
   endfunction
   function automatic logic [7:0] byte_b();
      return {3'b0, m_sle, 3'b0, busy};
   endfunction

   task automatic xfer_bit(input bit b, output bit so_v, output bit oe_v);
      @(negedge clk);
      si = b;
      repeat (HALF) @(negedge clk);
      so_v = so;
      oe_v = so_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic select();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic deselect();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (4*HALF) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v, input string req);
      bit s, o;
      int oe_seen = 0;
      for (int i = 7; i >= 0; i--) begin
         xfer_bit(v[i], s, o);
         if (o) oe_seen++;
      end
      check(oe_seen == 0, req, "SO driven while shifting in", oe_seen, 0);
   endtask

   task automatic command(input logic [7:0] op, input string req);
      select();
      send_byte(op, req);
      deselect();
   endtask

   task automatic write_b(input logic [7:0] d, input string req);
      select();
      send_byte(8'h31, req);
      send_byte(d, req);
      deselect();
      if (!m_frozen) m_sle = d[4];
   endtask

   task automatic read_status(input int nbytes, input int flip_at, input string req);
      logic [7:0] exp_v, got;
      bit s, o;
      select();
      send_byte(8'h05, "R1");
      for (int k = 0; k < nbytes; k++) begin
         exp_v = (k % 2 == 0) ? byte_a() : byte_b();
         got = '0;
         for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b0, s, o);
            got[i] = s;
            if (!o) got[i] = 1'bx;
            if (k == flip_at && i == 4) begin
               busy = ~busy;
               ers  = ~ers;
            end
         end
         check(got === exp_v, req, $sformatf("status byte %0d", k), got, exp_v);
      end
      deselect();
      check(so_oe == 1'b0, "R2", "SO enable after deselect", so_oe, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int l0, f0, r0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      repeat (4) @(negedge clk);
      // R4: reset state
      check(lock_en == 1'b0, "R4", "enable after power-on", lock_en, 0);
      check(so_oe == 1'b0, "R4", "SO enable after power-on", so_oe, 0);
      check(n_lock + n_frz + n_rst == 0, "R4", "strobes after power-on", n_lock + n_frz + n_rst, 0);

      // R1 / R2: alternating read with two flag patterns
      busy = 1; pgm = 0; ers = 1;
      read_status(4, -1, "R2");
      busy = 0; pgm = 1; ers = 0;
      read_status(3, -1, "R1");

      // R5: lockdown and freeze ignored while disabled
      l0 = n_lock; f0 = n_frz;
      command(8'h33, "R5");
      command(8'h34, "R5");
      check(n_lock == l0, "R5", "lock strobes while disabled", n_lock - l0, 0);
      check(n_frz == f0, "R5", "freeze strobes while disabled", n_frz - f0, 0);
      check(lock_en == 1'b0, "R5", "enable after ignored commands", lock_en, 0);

      // R6: write sets the bit, and it persists
      write_b(8'h10, "R6");
      check(lock_en == 1'b1, "R6", "enable after write", lock_en, 1);
      busy = 1;
      read_status(2, -1, "R6");

      // R7: soft reset keeps the bit
      r0 = n_rst;
      command(8'hF0, "R7");
      check(n_rst == r0 + 1, "R7", "soft reset strobes", n_rst - r0, 1);
      check(lock_en == 1'b1, "R7", "enable after soft reset", lock_en, 1);

      // R3: flags change mid-byte
      busy = 0; pgm = 0; ers = 0;
      read_status(5, 1, "R3");
      read_status(2, 0, "R3");

      // R10: aborted write leaves the bit alone
      begin
         bit s, o;
         select();
         send_byte(8'h31, "R10");
         for (int i = 0; i < 4; i++) xfer_bit(1'b0, s, o);
         deselect();
      end
      check(lock_en == 1'b1, "R10", "enable after aborted write", lock_en, 1);
      read_status(2, -1, "R10");

      // R11: unknown opcode
      l0 = n_lock; f0 = n_frz; r0 = n_rst;
      select();
      send_byte(8'h9F, "R11");
      send_byte(8'h00, "R11");
      deselect();
      check(n_lock + n_frz + n_rst == l0 + f0 + r0, "R11", "strobes on unknown opcode",
            n_lock + n_frz + n_rst - l0 - f0 - r0, 0);

      // R9: lockdown accepted
      l0 = n_lock;
      command(8'h33, "R9");
      check(n_lock == l0 + 1, "R9", "lock strobes when enabled", n_lock - l0, 1);

      // R8: freeze, then write cannot restore the bit
      f0 = n_frz;
      command(8'h34, "R8");
      m_sle = 0; m_frozen = 1;
      check(n_frz == f0 + 1, "R8", "freeze strobes", n_frz - f0, 1);
      check(lock_en == 1'b0, "R8", "enable after freeze", lock_en, 0);
      write_b(8'h10, "R8");
      check(lock_en == 1'b0, "R8", "enable after write while frozen", lock_en, 0);
      read_status(2, -1, "R8");
      l0 = n_lock;
      command(8'h33, "R8");
      check(n_lock == l0, "R8", "lock strobes after freeze", n_lock - l0, 0);

      // R8 / R4: power-on reset lifts the freeze
      @(negedge clk);
      por_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      m_sle = 0; m_frozen = 0;
      repeat (4) @(negedge clk);
      check(lock_en == 1'b0, "R4", "enable after second power-on", lock_en, 0);
      write_b(8'h10, "R8");
      check(lock_en == 1'b1, "R8", "enable writable after power-on", lock_en, 1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule